// File: doc/BRIEF.md
# Keyboard and Mouse Event Decoder

The decoder turns two host-fed status words into clean, single-cycle event pulses. The host signals a fresh keyboard or mouse event by inverting a marker bit in the relevant word. There is no valid strobe. The block remembers the marker value it saw on the previous clock. When the incoming marker disagrees with that value, it emits a one-clock pulse together with the fields of the word. For the keyboard it also keeps a live map of which keys are held down. The map has one bit per combination of extended flag and scancode, and any entry can be read through an index port.

Downstream logic uses the key pulse and fields to drive a scancode consumer. It uses the mouse pulse to accumulate motion. The index port serves logic that polls whether a particular key is currently held.

Top module: `kbm_event_decoder`

## Requirements
- R1: Reset is synchronous and active low, on `rst_n`. While it is low, and on the first clock after it rises, `key_evt` and `mouse_evt` stay low, and the event fields read zero. This holds even if the marker bits changed during reset. After reset every map entry reads 0.
- R2: A key event is detected when the key marker bit (`key_word[10]`) sampled at a rising edge differs from its value at the previous edge. `key_evt` is then high for exactly the one cycle after that edge. Flips on consecutive edges give a pulse on each of those cycles.
- R3: While `key_evt` is high, `key_code` equals `key_word[7:0]` from the detecting edge, `key_ext` equals bit 8 and `key_press` equals bit 9 (1 means press, 0 means release).
- R4: The map index is {extended flag, scancode}, so `map_idx[8]` selects extended codes. A key event sets the addressed entry on a press and clears it on a release. In the default read mode, `map_bit` shows entry `map_idx` combinationally and already reflects the event in the cycle where `key_evt` is high.
- R5: A repeated press of the same code produces another pulse and leaves the entry set. A single release then clears it. A release of a key that is not held produces a pulse and leaves the map unchanged.
- R6: Changes to `key_word[9:0]` without a marker flip produce no pulse and no map change.
- R7: A mouse event is detected when the mouse marker bit (`mouse_word[24]`) changes, with the same timing as R2. With `mouse_evt`, `mouse_btn` shows `mouse_word[7:0]`, `mouse_dx` shows `[15:8]` and `mouse_dy` shows `[23:16]`, both as two's complement.
- R8: Key and mouse detection are independent, so flips of both markers at one edge give both pulses in the same cycle.
- R9: Between events, every event field holds the value of the last event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_word | input | 11 | Keyboard word: marker, press, extended, scancode |
| mouse_word | input | 25 | Mouse word: marker, dy, dx, buttons |
| map_idx | input | 9 | Pressed-map read index {ext, code} |
| key_evt | output | 1 | One-cycle key event pulse |
| key_code | output | 8 | Scancode of the last key event |
| key_ext | output | 1 | Extended flag of the last key event |
| key_press | output | 1 | 1 press, 0 release, of the last key event |
| map_bit | output | 1 | Held state of map entry `map_idx` |
| mouse_evt | output | 1 | One-cycle mouse event pulse |
| mouse_btn | output | 8 | Button byte of the last mouse event |
| mouse_dx | output | 8 | Signed X movement of the last mouse event |
| mouse_dy | output | 8 | Signed Y movement of the last mouse event |

## Verification
A stale or corrupted marker register shows up as a missing pulse or a spurious pulse. It appears on the very next cycle after the offending edge, and it affects every later event as well. A wrong map entry is only visible once `map_idx` points at it, so the bench both sweeps the whole map after reset and steers the index to each key it touches. A field latched on the wrong edge appears during the pulse cycle. It then persists for as long as the hold period lasts.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
   // map read variant: combinational look-up or one flop after the array
   typedef enum logic {
      MAP_RD_COMB = 1'b0,
      MAP_RD_FLOP = 1'b1
   } map_rd_e;
endpackage

// File: rtl/kbm_toggle_edge.sv
module kbm_toggle_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic tog_in,
   output logic hit_o
);
   logic seen_q;

   // always tracks the marker, also during reset, so release is quiet
   always_ff @(posedge clk) begin
      seen_q <= tog_in;
   end

   assign hit_o = rst_n & (tog_in ^ seen_q);
endmodule

// File: rtl/kbm_key_unit.sv
module kbm_key_unit #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic              press_i,
   input  logic              ext_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              evt_o,
   output logic              press_o,
   output logic              ext_o,
   output logic [CODE_W-1:0] code_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_o   <= 1'b0;
         press_o <= 1'b0;
         ext_o   <= 1'b0;
         code_o  <= '0;
      end else begin
         evt_o <= hit_i;
         if (hit_i) begin
            press_o <= press_i;
            ext_o   <= ext_i;
            code_o  <= code_i;
         end
      end
   end
endmodule

// File: rtl/kbm_mouse_unit.sv
module kbm_mouse_unit #(
   parameter int BTN_W  = 8,
   parameter int MOVE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic [BTN_W-1:0]  btn_i,
   input  logic [MOVE_W-1:0] dx_i,
   input  logic [MOVE_W-1:0] dy_i,
   output logic              evt_o,
   output logic [BTN_W-1:0]  btn_o,
   output logic [MOVE_W-1:0] dx_o,
   output logic [MOVE_W-1:0] dy_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_o <= 1'b0;
         btn_o <= '0;
         dx_o  <= '0;
         dy_o  <= '0;
      end else begin
         evt_o <= hit_i;
         if (hit_i) begin
            btn_o <= btn_i;
            dx_o  <= dx_i;
            dy_o  <= dy_i;
         end
      end
   end
endmodule

// File: rtl/kbm_pressed_map.sv
module kbm_pressed_map
   import kbm_pkg::*;
#(
   parameter int      IDX_W   = 9,
   parameter map_rd_e RD_MODE = MAP_RD_COMB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_val,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] ent_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_q <= '0;
      end else if (wr_en) begin
         ent_q[wr_idx] <= wr_val;
      end
   end

   generate
      if (RD_MODE == MAP_RD_COMB) begin : g_rd_comb
         assign rd_bit = ent_q[rd_idx];
      end else begin : g_rd_flop
         logic rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= 1'b0;
            else        rd_q <= ent_q[rd_idx];
         end
         assign rd_bit = rd_q;
      end
   endgenerate
endmodule

// File: rtl/kbm_event_decoder.sv
module kbm_event_decoder
   import kbm_pkg::*;
#(
   parameter int      CODE_W = 8,
   parameter int      BTN_W  = 8,
   parameter int      MOVE_W = 8,
   parameter map_rd_e MAP_RD = MAP_RD_COMB
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [CODE_W+2:0]          key_word,
   input  logic [BTN_W+2*MOVE_W:0]    mouse_word,
   input  logic [CODE_W:0]            map_idx,
   output logic                       key_evt,
   output logic [CODE_W-1:0]          key_code,
   output logic                       key_ext,
   output logic                       key_press,
   output logic                       map_bit,
   output logic                       mouse_evt,
   output logic [BTN_W-1:0]           mouse_btn,
   output logic [MOVE_W-1:0]          mouse_dx,
   output logic [MOVE_W-1:0]          mouse_dy
);
   localparam int IDX_W   = CODE_W + 1;
   localparam int K_EXT   = CODE_W;
   localparam int K_PRS   = CODE_W + 1;
   localparam int K_TOG   = CODE_W + 2;
   localparam int M_DX_LO = BTN_W;
   localparam int M_DY_LO = BTN_W + MOVE_W;
   localparam int M_TOG   = BTN_W + 2 * MOVE_W;

   // elaboration-time parameter checks
   generate
      if (CODE_W < 1 || CODE_W > 12) begin : g_bad_code
         $error("CODE_W must lie in 1..12");
      end
      if (MOVE_W < 2) begin : g_bad_move
         $error("MOVE_W must be at least 2 for a signed value");
      end
      if (BTN_W < 1) begin : g_bad_btn
         $error("BTN_W must be at least 1");
      end
   endgenerate

   logic key_hit;
   logic mouse_hit;

   kbm_toggle_edge u_key_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .tog_in (key_word[K_TOG]),
      .hit_o  (key_hit)
   );

   kbm_toggle_edge u_mouse_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .tog_in (mouse_word[M_TOG]),
      .hit_o  (mouse_hit)
   );

   kbm_key_unit #(.CODE_W(CODE_W)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (key_hit),
      .press_i (key_word[K_PRS]),
      .ext_i   (key_word[K_EXT]),
      .code_i  (key_word[CODE_W-1:0]),
      .evt_o   (key_evt),
      .press_o (key_press),
      .ext_o   (key_ext),
      .code_o  (key_code)
   );

   kbm_pressed_map #(.IDX_W(IDX_W), .RD_MODE(MAP_RD)) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (key_hit),
      .wr_idx (key_word[K_EXT:0]),
      .wr_val (key_word[K_PRS]),
      .rd_idx (map_idx),
      .rd_bit (map_bit)
   );

   kbm_mouse_unit #(.BTN_W(BTN_W), .MOVE_W(MOVE_W)) u_mouse (
      .clk   (clk),
      .rst_n (rst_n),
      .hit_i (mouse_hit),
      .btn_i (mouse_word[BTN_W-1:0]),
      .dx_i  (mouse_word[M_DY_LO-1:M_DX_LO]),
      .dy_i  (mouse_word[M_TOG-1:M_DY_LO]),
      .evt_o (mouse_evt),
      .btn_o (mouse_btn),
      .dx_o  (mouse_dx),
      .dy_o  (mouse_dy)
   );
endmodule

// File: rtl/kbm_event_decoder_chk.sv
module kbm_event_decoder_chk
   import kbm_pkg::*;
#(
   parameter int      CODE_W = 8,
   parameter int      BTN_W  = 8,
   parameter int      MOVE_W = 8,
   parameter map_rd_e MAP_RD = MAP_RD_COMB
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [CODE_W+2:0]       key_word,
   input logic [BTN_W+2*MOVE_W:0] mouse_word,
   input logic [CODE_W:0]         map_idx,
   input logic                    key_evt,
   input logic [CODE_W-1:0]       key_code,
   input logic                    key_ext,
   input logic                    key_press,
   input logic                    map_bit,
   input logic                    mouse_evt,
   input logic [BTN_W-1:0]        mouse_btn,
   input logic [MOVE_W-1:0]       mouse_dx,
   input logic [MOVE_W-1:0]       mouse_dy
);
   localparam int K_TOG = CODE_W + 2;
   localparam int M_TOG = BTN_W + 2 * MOVE_W;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!key_evt && !mouse_evt && key_code == '0));

   // R2
   key_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (key_evt == ($past(key_word[K_TOG]) != $past(key_word[K_TOG], 2))));

   // R3
   key_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_evt |-> (key_code == $past(key_word[CODE_W-1:0]) &&
                   key_ext == $past(key_word[CODE_W]) &&
                   key_press == $past(key_word[CODE_W+1])));

   // R7
   mouse_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (mouse_evt == ($past(mouse_word[M_TOG]) != $past(mouse_word[M_TOG], 2))));

   // R7
   mouse_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mouse_evt |-> (mouse_btn == $past(mouse_word[BTN_W-1:0]) &&
                     mouse_dx == $past(mouse_word[BTN_W+MOVE_W-1:BTN_W]) &&
                     mouse_dy == $past(mouse_word[M_TOG-1:BTN_W+MOVE_W])));

   // R9
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !key_evt) |-> $stable(key_code));

   generate
      if (MAP_RD == MAP_RD_COMB) begin : g_map_chk
         // R4
         map_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (key_evt && map_idx == {key_ext, key_code}) |-> (map_bit == key_press));
      end
   endgenerate
endmodule

bind kbm_event_decoder kbm_event_decoder_chk #(
   .CODE_W (CODE_W),
   .BTN_W  (BTN_W),
   .MOVE_W (MOVE_W),
   .MAP_RD (MAP_RD)
) u_chk (.*);

// File: tb/kbm_event_decoder_test.sv
module kbm_event_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] key_word = 11'h400;
   logic [24:0] mouse_word = 25'h1_05F0_03;
   logic [8:0]  map_idx = 9'h0;
   logic        key_evt, key_ext, key_press, map_bit, mouse_evt;
   logic [7:0]  key_code, mouse_btn, mouse_dx, mouse_dy;

   kbm_event_decoder uut (
      .clk(clk), .rst_n(rst_n), .key_word(key_word), .mouse_word(mouse_word),
      .map_idx(map_idx), .key_evt(key_evt), .key_code(key_code),
      .key_ext(key_ext), .key_press(key_press), .map_bit(map_bit),
      .mouse_evt(mouse_evt), .mouse_btn(mouse_btn), .mouse_dx(mouse_dx),
      .mouse_dy(mouse_dy)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int kev_cnt = 0;
   bit done = 1'b0;

   // behavioural reference model
   bit       m_map [512];
   bit       m_ktog, m_mtog, m_kev, m_mev, m_ext, m_prs;
   bit [7:0] m_code, m_btn, m_dx, m_dy;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (key_evt === 1'b1) kev_cnt++;
      if (!rst_n) begin
         foreach (m_map[i]) m_map[i] = 1'b0;
         m_kev = 0; m_mev = 0; m_ext = 0; m_prs = 0;
         m_code = 0; m_btn = 0; m_dx = 0; m_dy = 0;
      end else begin
         m_kev = (key_word[10] != m_ktog);
         m_mev = (mouse_word[24] != m_mtog);
         if (m_kev) begin
            m_code = key_word[7:0];
            m_ext  = key_word[8];
            m_prs  = key_word[9];
            m_map[int'({key_word[8], key_word[7:0]})] = key_word[9];
         end
         if (m_mev) begin
            m_btn = mouse_word[7:0];
            m_dx  = mouse_word[15:8];
            m_dy  = mouse_word[23:16];
         end
      end
      m_ktog = key_word[10];
      m_mtog = mouse_word[24];
   end

   always @(negedge clk) begin
      if (!done) begin
         chk("R2 key_evt", key_evt, m_kev);
         chk(m_kev ? "R3 key fields" : "R9 key hold", {key_press, key_ext, key_code},
             {m_prs, m_ext, m_code});
         chk("R4 map_bit", map_bit, m_map[int'(map_idx)]);
         chk("R7 mouse_evt", mouse_evt, m_mev);
         chk(m_mev ? "R7 mouse fields" : "R9 mouse hold", {mouse_btn, mouse_dx, mouse_dy},
             {m_btn, m_dx, m_dy});
      end
   end

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic settle();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic send_key(input bit ext, input bit prs, input bit [7:0] code);
      step();
      key_word = {~key_word[10], prs, ext, code};
      map_idx  = {ext, code};
      settle();
   endtask

   task automatic send_mouse(input bit [7:0] btn, input bit [7:0] dx, input bit [7:0] dy);
      step();
      mouse_word = {~mouse_word[24], dy, dx, btn};
      settle();
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual running expected finished");
      finish_run();
   end

   initial begin
      int c0;
      // R1: quiet reset, marker flipped while in reset
      repeat (3) step();
      @(negedge clk);
      chk("R1 key_evt in reset", key_evt, 0);
      chk("R1 mouse_evt in reset", mouse_evt, 0);
      step();
      key_word[10] = 1'b0;
      mouse_word[24] = 1'b0;
      settle();
      chk("R1 no pulse in reset", {key_evt, mouse_evt}, 0);
      step();
      rst_n = 1'b1;
      settle();
      chk("R1 first cycle quiet", {key_evt, mouse_evt}, 0);
      chk("R1 fields zero", {key_code, mouse_dx}, 0);
      for (int i = 0; i < 512; i++) begin
         step();
         map_idx = 9'(i);
         @(negedge clk);
         chk("R1 map clear", map_bit, 0);
      end

      // R2, R3, R4: presses of plain and extended versions of one code
      send_key(0, 1, 8'h1C);
      chk("R2 pulse", key_evt, 1);
      chk("R3 code", {key_press, key_ext, key_code}, {1'b1, 1'b0, 8'h1C});
      chk("R4 set", map_bit, 1);
      send_key(1, 1, 8'h1C);
      chk("R3 ext", key_ext, 1);
      step();
      map_idx = 9'h01C;
      settle();
      chk("R2 single pulse", key_evt, 0);
      chk("R4 plain kept", map_bit, 1);
      send_key(0, 0, 8'h1C);
      chk("R4 cleared", map_bit, 0);
      step();
      map_idx = 9'h11C;
      settle();
      chk("R4 ext kept", map_bit, 1);

      // R5: repeated press, then stray release
      step();
      c0 = kev_cnt;
      send_key(0, 1, 8'h29);
      send_key(0, 1, 8'h29);
      step();
      chk("R5 two pulses", kev_cnt - c0, 2);
      map_idx = 9'h029;
      @(negedge clk);
      chk("R5 still set", map_bit, 1);
      send_key(0, 0, 8'h29);
      chk("R5 single release clears", map_bit, 0);
      send_key(0, 0, 8'h55);
      chk("R5 stray release pulse", key_evt, 1);
      chk("R5 stray release map", map_bit, 0);

      // R6: field changes with no marker flip
      step();
      map_idx = 9'h11C;
      key_word[9:0] = {1'b0, 1'b1, 8'h1C};
      settle();
      chk("R6 no pulse", key_evt, 0);
      chk("R6 map kept", map_bit, 1);
      step();
      key_word[9:0] = 10'h3A5;
      settle();
      chk("R6 no pulse again", key_evt, 0);
      chk("R6 map kept again", map_bit, 1);

      // R7, R9: mouse events with negative motion
      send_mouse(8'h09, 8'hFD, 8'h7F);
      chk("R7 pulse", mouse_evt, 1);
      chk("R7 fields", {mouse_btn, mouse_dx, mouse_dy}, {8'h09, 8'hFD, 8'h7F});
      settle();
      chk("R9 mouse hold", {mouse_evt, mouse_dx}, {1'b0, 8'hFD});
      send_mouse(8'h00, 8'h80, 8'hF8);
      chk("R7 fields 2", {mouse_dx, mouse_dy}, {8'h80, 8'hF8});

      // R8: simultaneous events
      step();
      key_word = {~key_word[10], 1'b1, 1'b0, 8'h33};
      mouse_word = {~mouse_word[24], 8'h01, 8'h02, 8'h03};
      map_idx = 9'h033;
      settle();
      chk("R8 both pulses", {key_evt, mouse_evt}, 2'b11);
      chk("R8 map", map_bit, 1);

      // R2: back-to-back flips
      step();
      c0 = kev_cnt;
      key_word = {~key_word[10], 1'b1, 1'b0, 8'h40};
      step();
      key_word = {~key_word[10], 1'b1, 1'b0, 8'h41};
      step();
      key_word = {~key_word[10], 1'b0, 1'b0, 8'h40};
      repeat (2) step();
      chk("R2 consecutive pulses", kev_cnt - c0, 3);

      // R1: reset in mid-run clears map, marker flips during reset are silent
      rst_n = 1'b0;
      key_word[10] = ~key_word[10];
      mouse_word[24] = ~mouse_word[24];
      map_idx = 9'h11C;
      repeat (2) step();
      rst_n = 1'b1;
      settle();
      chk("R1 quiet after reset", {key_evt, mouse_evt}, 0);
      chk("R1 map cleared", map_bit, 0);

      // mixed traffic against the model
      for (int n = 0; n < 600; n++) begin
         step();
         if ($urandom_range(0, 2) == 0)
            key_word = {~key_word[10], 1'($urandom), 1'($urandom), 5'd0, 3'($urandom)};
         else
            key_word[9:0] = 10'($urandom);
         if ($urandom_range(0, 3) == 0)
            mouse_word = {~mouse_word[24], 24'($urandom)};
         map_idx = {1'($urandom), 5'd0, 3'($urandom)};
      end
      settle();
      finish_run();
   end
endmodule